// File: doc/BRIEF.md
# Recursive Pulse Time/Phase Shifter

This block takes a periodic input pulse train and produces an output pulse train that settles on the same period but is displaced in time by an amount the user picks. It does not measure the phase error directly. It keeps a signed time-difference count τ. At every output period boundary, τ grows by the length of the output period that just ended and shrinks by the length of the last measured input period. The next output period is then computed as TI_gain + T − τ and loaded into a period generator. The loop gain is fixed at −1, so a constant input locks in two updates.

The displacement comes from two knobs. The signed control word T moves the output edges by exactly T reference cycles. The measurement enable `meas_en` sets the effective gain a, because the gain-path input period is counted only on cycles where the enable is high. Running the enable at a fraction a of the clock adds a displacement proportional to the input period, (a − 1)·TI, which acts as a phase shift. With T = 0 and the enable held high, the block behaves as an ordinary phase lock.

Top module: `pulse_phase_shifter`

## Requirements
- R1: During and after reset, `pulse_out` is low. The generated period is INIT_PER (default 64) and τ is 0. The first output falling edge comes INIT_PER cycles after the first clock edge with reset released.
- R2: A generated period of N cycles is low for floor(N/2) cycles and then high for the rest. Its falling edge comes at the end of the period, and that cycle is the update step.
- R3: No update happens until two detected input falling edges have been seen, which is one complete measured input period. Until then every output period is INIT_PER and τ stays 0, including when the input has no edge or only one falling edge.
- R4: `pulse_in` passes through a SYNC_STAGES flop synchronizer, and its falling edges are detected. TI_ref is the number of clock cycles between successive detected falling edges. TI_gain is the number of cycles in that same interval on which `meas_en` is high. Both counts saturate at 2^PER_W − 1.
- R5: At each update step, τ becomes τ + TO − TI_ref. TO is the length of the output period that just ended. The result saturates to the signed TAU_W range.
- R6: The next period is TI_gain + T − τ, using the freshly updated τ. It is clamped to the range 2 to 2^PER_W − 1 and takes effect only when the current period ends.
- R7: Take a constant input period TI, `meas_en` held high, and no clamping. The first updated period is 2·TI + T − INIT_PER, and every later period is TI. The output edges end up exactly T cycles later than in a run with T = 0.
- R8: Take a constant input period TI, with `meas_en` high on one cycle in d, where d divides TI. The output periods still settle on TI. The output edges end up displaced by (TI/d − TI) + T cycles relative to the T = 0, full-enable run.
- R9: When the computed period falls outside the range 2 to 2^PER_W − 1, the clamped value is emitted. The recursion then continues from the τ that this clamped period produces, and it settles on TI.
- R10: R5 to R7 hold for every phase offset between the input train and the output train. This includes the case where an input falling edge is detected in the same cycle as an update step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; τ, T and output periods are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_en | input | 1 | Enable for the gain-path input period count (sets gain a) |
| pulse_in | input | 1 | Input pulse train, asynchronous |
| shift_word | input | CTRL_W | Signed time-shift control word T |
| pulse_out | output | 1 | Shifted output pulse train |

## Verification
Two of the block's functions can fall in the same cycle: capturing a new input period at a detected input falling edge, and the update step at the end of an output period. The bench provokes this by sweeping the start delay of the input train over every cycle of a 40-cycle input period. That moves the detected input edges across all positions relative to the 64-cycle initial output period, so some runs put both events in the same cycle. For each sweep point, the bench predicts the full sequence of output periods from the recursion and compares every measured interval between output falling edges. A mistake in choosing between the stored and the fresh input period, or in the start of τ accumulation, shows up as a wrong interval.

// File: rtl/tps_pkg.sv
// Shared constants and helpers for the recursive pulse shifter.
// Assumes all arithmetic fits in 32-bit signed integers.
package tps_pkg;

    // Smallest period the generator can emit (one low and one high cycle).
    localparam int MIN_PERIOD = 2;

    // Clip a signed integer into the closed range [lo, hi].
    function automatic int clip_int(input int v, input int lo, input int hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/tps_in_meas.sv
// Input measurement: synchronizes the input pulse, detects its falling
// edges and counts two versions of the input period. One counts every
// reference cycle; the other counts only cycles with meas_en high.
// Assumes SYNC_STAGES >= 2. The result is valid once a full period lies
// between two detected falling edges.
module tps_in_meas #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             meas_en,
    output logic [CNT_W-1:0] ti_ref,
    output logic [CNT_W-1:0] ti_gain,
    output logic             ti_valid
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   in_fall;
    logic                   seen_q;
    logic [CNT_W-1:0]       ref_cnt;
    logic [CNT_W-1:0]       gain_cnt;
    logic [CNT_W-1:0]       ref_inc;
    logic [CNT_W-1:0]       gain_inc;

    // Synchronizer shift chain plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign in_fall = last_q & ~sync_q[SYNC_STAGES-1];

    // Saturating next values of both period counters.
    assign ref_inc  = (&ref_cnt)  ? ref_cnt  : ref_cnt + CNT_W'(1);
    assign gain_inc = (&gain_cnt) ? gain_cnt : gain_cnt + CNT_W'(meas_en);

    // Period counters: capture and restart at each detected falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt  <= '0;
            gain_cnt <= '0;
            ti_ref   <= '0;
            ti_gain  <= '0;
            seen_q   <= 1'b0;
            ti_valid <= 1'b0;
        end else if (in_fall) begin
            ti_ref   <= ref_inc;
            ti_gain  <= gain_inc;
            ref_cnt  <= '0;
            gain_cnt <= '0;
            seen_q   <= 1'b1;
            ti_valid <= ti_valid | seen_q;
        end else begin
            ref_cnt  <= ref_inc;
            gain_cnt <= gain_inc;
        end
    end

    // R4: once a complete period has been measured, it stays measured.
    a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ti_valid |=> ti_valid);

    // R4: a valid reference-path period is never zero cycles long.
    a_r4_ref_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ti_valid |-> (ti_ref != '0));

endmodule

// File: rtl/tps_update.sv
// Recursive update: holds the signed time-difference count tau. At each
// valid step it adds the output period just ended and subtracts the
// measured reference input period. It also forms the clamped next output
// period TI_gain + T - tau_new. Assumes step is the last cycle of the
// current output period.
module tps_update #(
    parameter int PER_W  = 8,
    parameter int TAU_W  = 8,
    parameter int CTRL_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic                     ti_valid,
    input  logic [PER_W-1:0]         ti_ref,
    input  logic [PER_W-1:0]         ti_gain,
    input  logic [PER_W-1:0]         cur_per,
    input  logic signed [CTRL_W-1:0] shift_word,
    output logic [PER_W-1:0]         next_per
);
    localparam int TAU_MAX = (2 ** (TAU_W - 1)) - 1;
    localparam int TAU_MIN = -(2 ** (TAU_W - 1));
    localparam int PER_MAX = (2 ** PER_W) - 1;

    logic signed [TAU_W-1:0] tau_q;
    logic signed [TAU_W-1:0] tau_next;
    int                      tau_sum;
    int                      raw_per;

    // Next tau and next period, computed from the current registers.
    always_comb begin
        tau_sum  = int'(tau_q) + int'(cur_per) - int'(ti_ref);
        tau_next = TAU_W'(tps_pkg::clip_int(tau_sum, TAU_MIN, TAU_MAX));
        raw_per  = int'(ti_gain) + int'(shift_word) - int'(tau_next);
        next_per = PER_W'(tps_pkg::clip_int(raw_per, tps_pkg::MIN_PERIOD, PER_MAX));
    end

    // Tau register: advances only at a step with a measured input period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tau_q <= '0;
        else if (step && ti_valid)
            tau_q <= tau_next;
    end

    // R3: tau stays at zero until the input period has been measured.
    a_r3_tau_zero_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ti_valid |-> (tau_q == '0));

    // R5: tau changes only at update steps.
    a_r5_tau_moves_at_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(tau_q));

endmodule

// File: rtl/tps_period_gen.sv
// Programmable period generator. It counts through the current period,
// drives the output low for the first half and high for the second half,
// and flags the last cycle as the update step. At that step it loads the
// new period if the input period is valid. Assumes next_per >= 2.
module tps_period_gen #(
    parameter int PER_W    = 8,
    parameter int INIT_PER = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [PER_W-1:0] next_per,
    output logic [PER_W-1:0] cur_per,
    output logic             step,
    output logic             pulse_out
);
    logic [PER_W-1:0] cnt_q;

    assign step      = (cnt_q == cur_per - PER_W'(1));
    assign pulse_out = (cnt_q >= (cur_per >> 1));

    // Position counter and period register; reload only at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cur_per <= PER_W'(INIT_PER);
        end else if (step) begin
            cnt_q <= '0;
            if (load_en)
                cur_per <= next_per;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    // R2: the last cycle of a period is high and the next cycle is low.
    a_r2_high_at_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> pulse_out);
    a_r2_low_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !pulse_out);

    // R6: the period changes only across a period boundary.
    a_r6_reload_at_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cur_per));

    // R6: the period never drops below the two-cycle floor.
    a_r6_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cur_per >= PER_W'(tps_pkg::MIN_PERIOD));

endmodule

// File: rtl/pulse_phase_shifter.sv
// Top level of the recursive pulse time/phase shifter. It joins the input
// measurement, the tau/next-period update and the period generator. All
// timing is counted in clk cycles; meas_en scales the gain-path count.
module pulse_phase_shifter #(
    parameter int PER_W       = 8,
    parameter int TAU_W       = 8,
    parameter int CTRL_W      = 8,
    parameter int INIT_PER    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     meas_en,
    input  logic                     pulse_in,
    input  logic signed [CTRL_W-1:0] shift_word,
    output logic                     pulse_out
);
    logic [PER_W-1:0] ti_ref;
    logic [PER_W-1:0] ti_gain;
    logic             ti_valid;
    logic [PER_W-1:0] cur_per;
    logic [PER_W-1:0] next_per;
    logic             step;

    tps_in_meas #(
        .CNT_W      (PER_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_in(pulse_in),
        .meas_en (meas_en),
        .ti_ref  (ti_ref),
        .ti_gain (ti_gain),
        .ti_valid(ti_valid)
    );

    tps_update #(
        .PER_W (PER_W),
        .TAU_W (TAU_W),
        .CTRL_W(CTRL_W)
    ) u_update (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .ti_valid  (ti_valid),
        .ti_ref    (ti_ref),
        .ti_gain   (ti_gain),
        .cur_per   (cur_per),
        .shift_word(shift_word),
        .next_per  (next_per)
    );

    tps_period_gen #(
        .PER_W   (PER_W),
        .INIT_PER(INIT_PER)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ti_valid),
        .next_per (next_per),
        .cur_per  (cur_per),
        .step     (step),
        .pulse_out(pulse_out)
    );

    // R1: while reset is held, the output stays low.
    a_r1_low_in_reset: assert property (@(posedge clk)
        !rst_n |=> !pulse_out);

endmodule

// File: tb/pulse_phase_shifter_test.sv
// Self-checking bench: drives periodic input trains with chosen period,
// start delay, enable ratio and shift word. It records the times of the
// output falling edges and compares every interval with a recursion model.
module pulse_phase_shifter_test;
    localparam int INIT = 64;
    localparam int RUN  = 1600;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              meas_en = 1'b0;
    logic              pulse_in = 1'b0;
    logic signed [7:0] shift_word = '0;
    logic              pulse_out;

    int checks = 0;
    int errors = 0;

    int p_per = 40, p_dly = 0, p_div = 1, p_np = 0;
    int cyc, ph, pcnt, nfall;
    logic prev_out;
    int fall_t [0:63];

    pulse_phase_shifter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_en   (meas_en),
        .pulse_in  (pulse_in),
        .shift_word(shift_word),
        .pulse_out (pulse_out)
    );

    always #4 clk = ~clk;

    // Stimulus and sampling, both away from the active (rising) edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; ph = 0; pcnt = 0; nfall = 0;
            prev_out = 1'b0; pulse_in = 1'b0; meas_en = 1'b0;
        end else begin
            if (prev_out && !pulse_out && nfall < 64) begin
                fall_t[nfall] = cyc;
                nfall++;
            end
            prev_out = pulse_out;
            cyc++;
            meas_en = ((cyc % p_div) == 0);
            if (cyc >= p_dly && pcnt < p_np) begin
                pulse_in = (ph < p_per / 2);
                ph++;
                if (ph == p_per) begin
                    ph = 0;
                    pcnt++;
                end
            end else begin
                pulse_in = 1'b0;
            end
        end
    end

    function automatic int clampv(input int v);
        if (v < 2)   return 2;
        if (v > 255) return 255;
        return v;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Reset, run, then check reset state, first edge and period sequence.
    task automatic run_case(input int per, input int dly, input int dv, input int t,
                            input int np, output int f_idx, output int t_mark);
        int tau;
        int exp;
        int f;
        @(posedge clk); #1;
        rst_n = 1'b0;
        p_per = per; p_dly = dly; p_div = dv; p_np = np;
        shift_word = 8'(t);
        repeat (4) @(posedge clk);
        #1;
        check("R1", "pulse_out in reset", int'(pulse_out), 0);
        rst_n = 1'b1;
        repeat (RUN) @(posedge clk);
        #1;
        check("R1", "first fall time", (nfall > 0) ? fall_t[0] : -1, INIT);
        f_idx = -1;
        t_mark = 0;
        if (np < 2) begin
            // R3: no complete input period, so every interval stays INIT
            for (int j = 0; j + 1 < nfall; j++)
                check("R3", "interval without measured period",
                      fall_t[j+1] - fall_t[j], INIT);
            return;
        end
        f = -1;
        for (int j = 0; j + 1 < nfall; j++)
            if (f < 0 && fall_t[j+1] - fall_t[j] != INIT) f = j;
        checks++;
        if (f < 0 || f + 9 >= nfall) begin
            errors++;
            $display("FAIL R3: update edge index got %0d expected a change with %0d falls", f, nfall);
            return;
        end
        // R2 low half: pulse falls at step, and step marks the period end
        tau = INIT - per;
        for (int j = f; j < f + 8; j++) begin
            exp = clampv(per / dv + t - tau);
            // R4 R5 R6 R9 R10: each interval follows the recursion
            check((j == f) ? "R6" : "R5", "output period", fall_t[j+1] - fall_t[j], exp);
            tau = tau + exp - per;
        end
        // R7: settled period equals the input period
        check("R7", "settled period", fall_t[f+9] - fall_t[f+8], per);
        f_idx = f;
        t_mark = fall_t[f+8];
    endtask

    initial begin
        int f0, m0, f1, m1;
        // R1 R3: no input edges at all
        run_case(40, 5, 1, 0, 0, f1, m1);
        // R3: exactly one input falling edge
        run_case(40, 5, 1, 0, 1, f1, m1);
        // R7: baseline for the displacement checks
        run_case(40, 5, 1, 0, 1000, f0, m0);
        check("R7", "first updated period index known", int'(f0 >= 0), 1);
        // R7: positive shift word delays the edges by T
        run_case(40, 5, 1, 7, 1000, f1, m1);
        check("R7", "same update index", f1, f0);
        check("R7", "edge displacement T=7", m1 - m0, 7);
        // R7: negative shift word
        run_case(40, 5, 1, -5, 1000, f1, m1);
        check("R7", "edge displacement T=-5", m1 - m0, -5);
        // R8: enable one cycle in two, T = 0
        run_case(40, 5, 2, 0, 1000, f1, m1);
        check("R8", "edge displacement a=1/2", m1 - m0, 20 - 40);
        // R8: enable one cycle in four, T = 10
        run_case(40, 5, 4, 10, 1000, f1, m1);
        check("R8", "edge displacement a=1/4 T=10", m1 - m0, 10 - 40 + 10);
        // R9: lower clamp twice in a row, then recovery
        run_case(40, 5, 1, -60, 1000, f1, m1);
        check("R9", "edge displacement after low clamp", m1 - m0, -60);
        // R9: upper clamp with a long input period
        run_case(100, 3, 1, 120, 1000, f1, m1);
        // R10: sweep input start phase over a full input period
        for (int d = 0; d < 40; d++)
            run_case(40, d, 1, (d % 9) - 4, 1000, f1, m1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: cycles got %0d expected below %0d", 190000, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule